// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block derives a steady 1 MHz event rate from whatever reference clock the chip happens to run on. It does this with a fractional accumulator prescaler rather than an integer divider. A configuration word holds a dividend and a divisor, each stored minus one. On every reference cycle the accumulator adds the dividend. Whenever the running sum reaches the divisor, the divisor is subtracted and one tick is issued. Over time the tick rate is exactly the reference rate multiplied by dividend/divisor, even when that ratio is not the reciprocal of an integer. For example, a 19.2 MHz reference with a 5/96 ratio gives exactly 1 MHz.

Each tick advances a free-running up-counter of microseconds, which wraps to zero. The same tick is driven out for one cycle so that neighbouring timers can run on it. A small register port exposes three registers: the counter (read only), the configuration word and a freeze control. While freeze is set, the accumulator, the counter and the tick output all stand still.

Top module: `usec_timebase`

## Requirements
- R1: After reset the counter (offset 0x10) reads 0, the configuration (offset 0x14) reads 0x0000000B, freeze (offset 0x4C) reads 0, and the tick output is low.
- R2: The configuration word holds divisor-1 in bits [7:0] and dividend-1 in bits [15:8]. Written bits above bit 15 are dropped and read back as zero.
- R3: A configuration write clears the accumulator and neither ticks nor counts in its own cycle. N cycles after that write edge, with dividend d no larger than divisor D, the counter has advanced by exactly floor(N*d/D).
- R4: The tick output is high for one cycle exactly when the counter has just advanced by one, and the counter is unchanged in every other cycle.
- R5: When the dividend is equal to or larger than the divisor, a tick is issued on every cycle.
- R6: The counter wraps from all ones to zero on the next tick.
- R7: Writing 1 to bit 0 of the freeze register stops the counter, the ticks and the accumulator from the following cycle onward. Reads return the held value. Writing 0 resumes counting at the accumulator phase that was held.
- R8: Writes to the counter offset have no effect.
- R9: Reads of any unmapped offset return zero, and bits above bit 0 of the freeze register read as zero.
- R10: The configuration values 0x000B, 0x000C, 0x0019 and 0x045F give exactly one tick per microsecond for references of 12, 13, 26 and 19.2 MHz respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for the addressed register, combinational |
| tickOut | output | 1 | One-cycle pulse per microsecond |

## Verification
Read data follows the address in the same cycle, so the bench samples it at the falling edge after it sets the address. The counter and the tick output are both registered. They change at the same rising edge as the accumulator step that produces them, so the bench checks that they agree at every falling edge.

Every expected count is taken from a cycle count that starts at the edge of the configuration write. That edge itself produces no tick. During a freeze, the edge that writes the freeze still counts as active and the edge that clears it does not, and the arithmetic in the bench counts the cycles accordingly.

// File: rtl/usTbPkg.sv
package usTbPkg;
  typedef struct packed {
    logic tick;
    logic selCount;
    logic selCfg;
    logic selFrz;
  } strobe_t;

  localparam logic [7:0] OFS_COUNT = 8'h10;
  localparam logic [7:0] OFS_CFG   = 8'h14;
  localparam logic [7:0] OFS_FRZ   = 8'h4C;
endpackage

// File: rtl/usTbCtrl.sv
module usTbCtrl
  import usTbPkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned FIELD_W   = 8,
  parameter int unsigned CFG_W     = 2 * FIELD_W,
  parameter int unsigned CFG_RESET = 'h000B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CFG_W-1:0]  wrField,
  output logic [CFG_W-1:0]  cfgVal,
  output logic              frzVal,
  output strobe_t           strb
);
  localparam int unsigned ACC_W = FIELD_W + 2;

  logic [CFG_W-1:0] cfgReg;
  logic             frzReg;
  logic [ACC_W-1:0] acc, accSum, accWrapped, accNext, divisor, dividend;
  logic             reached, cfgWr, frzWr;

  assign divisor  = ACC_W'(cfgReg[FIELD_W-1:0]) + ACC_W'(1);
  assign dividend = ACC_W'(cfgReg[CFG_W-1:FIELD_W]) + ACC_W'(1);
  assign accSum   = acc + dividend;
  assign reached  = accSum >= divisor;
  assign accWrapped = accSum - divisor;

  always_comb begin
    if (!reached)                 accNext = accSum;
    else if (accWrapped >= divisor) accNext = '0;
    else                          accNext = accWrapped;
  end

  assign cfgWr = wrEn && (addr == ADDR_W'(OFS_CFG));
  assign frzWr = wrEn && (addr == ADDR_W'(OFS_FRZ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= CFG_W'(CFG_RESET);
      frzReg <= 1'b0;
      acc    <= '0;
    end else begin
      if (cfgWr) cfgReg <= wrField;
      if (frzWr) frzReg <= wrField[0];
      if (cfgWr)        acc <= '0;
      else if (!frzReg) acc <= accNext;
    end
  end

  assign strb.tick     = reached && !frzReg && !cfgWr;
  assign strb.selCount = addr == ADDR_W'(OFS_COUNT);
  assign strb.selCfg   = addr == ADDR_W'(OFS_CFG);
  assign strb.selFrz   = addr == ADDR_W'(OFS_FRZ);
  assign cfgVal = cfgReg;
  assign frzVal = frzReg;

  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    acc < divisor);
  assert_cfg_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (acc == '0));
endmodule

// File: rtl/usTbDatapath.sv
module usTbDatapath
  import usTbPkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COUNT_W = 32,
  parameter int unsigned CFG_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CFG_W-1:0]  cfgVal,
  input  logic              frzVal,
  output logic [DATA_W-1:0] rdData,
  output logic              tickOut
);
  logic [COUNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      tickOut <= 1'b0;
    end else begin
      tickOut <= strb.tick;
      if (strb.tick) count <= count + COUNT_W'(1);
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.selCount)    rdData = DATA_W'(count);
    else if (strb.selCfg) rdData = DATA_W'(cfgVal);
    else if (strb.selFrz) rdData = DATA_W'(frzVal);
  end

  assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> (count == $past(count) + COUNT_W'(1)));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tickOut |-> $stable(count));
  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    frzVal |=> $stable(count));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usTbPkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned COUNT_W   = 32,
  parameter int unsigned FIELD_W   = 8,
  parameter int unsigned CFG_RESET = 'h000B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              tickOut
);
  localparam int unsigned CFG_W = 2 * FIELD_W;

  strobe_t          strb;
  logic [CFG_W-1:0] cfgVal;
  logic             frzVal;

  usTbCtrl #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .CFG_W(CFG_W), .CFG_RESET(CFG_RESET)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrField(wrData[CFG_W-1:0]), .cfgVal(cfgVal), .frzVal(frzVal), .strb(strb)
  );

  usTbDatapath #(
    .DATA_W(DATA_W), .COUNT_W(COUNT_W), .CFG_W(CFG_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgVal(cfgVal), .frzVal(frzVal),
    .rdData(rdData), .tickOut(tickOut)
  );
endmodule

// File: tb/usec_timebase_tb.sv
module usec_timebase_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int WRAP = 1 << CW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tickOut;
  int vectors = 0;
  int miscompares = 0;

  usec_timebase #(.COUNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .tickOut(tickOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  // Writes cfg, then runs n cycles while checking tick/count agreement every cycle.
  task automatic runCfg(input logic [15:0] cfg, input int n, input string tag);
    logic [31:0] base, cur, prev;
    int d, dv, ticks, expTicks, bad;
    d  = int'(cfg[15:8]) + 1;
    dv = int'(cfg[7:0]) + 1;
    regWrite(8'h14, {16'h0, cfg});
    regRead(8'h10, base);
    prev = base; ticks = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = rdData;
      if (tickOut) begin
        ticks++;
        if (cur != (prev + 1) % WRAP) bad++;   // R4, R6: step by one, wrap to zero
      end else if (cur != prev) bad++;         // R4: no tick, no change
      prev = cur;
    end
    expTicks = (d >= dv) ? n : (n * d) / dv;   // R5 / R3
    check({tag, " R4 R6 tick-count agreement"}, bad, 0);
    check({tag, " R3 R5 tick total"}, ticks, expTicks);
    check({tag, " R3 counter value"}, cur, (base + expTicks) % WRAP);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] v, held, base;
    int tickSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead(8'h10, v); check("R1 counter", v, 0);
    regRead(8'h14, v); check("R1 config", v, 32'h0000000B);
    regRead(8'h4C, v); check("R1 freeze", v, 0);
    check("R1 tick", {31'h0, tickOut}, 0);
    addr = 8'h10;
    repeat (120) @(negedge clk);
    regRead(8'h10, v); check("R10 default 12MHz ratio", v, 10);

    // R2 field layout and upper bits dropped
    regWrite(8'h14, 32'hABCD_1234);
    regRead(8'h14, v); check("R2 config readback", v, 32'h0000_1234);

    // R10 standard rates
    runCfg(16'h000B, 240, "R10 12MHz");
    runCfg(16'h000C, 260, "R10 13MHz");
    runCfg(16'h0019, 520, "R10 26MHz");
    runCfg(16'h045F, 960, "R10 19.2MHz");

    // R3 R5 sweep of small ratios
    for (int dd = 0; dd < 4; dd++)
      for (int dv = 0; dv < 6; dv++)
        runCfg({8'(dd), 8'(dv)}, 60, "R3 sweep");

    // R6 wrap with 1:1 ratio
    runCfg(16'h0000, 1100, "R6 wrap");

    // R7 freeze, R8 counter write ignored
    regWrite(8'h14, 32'h0000_0103);            // d=2, D=4
    regRead(8'h10, base);
    addr = 8'h10;
    repeat (5) @(negedge clk);
    regWrite(8'h4C, 32'h1);                    // this edge still active
    regRead(8'h10, held);
    tickSeen = 0;
    addr = 8'h10;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tickOut) tickSeen++;
    end
    regRead(8'h10, v); check("R7 counter held", v, held);
    check("R7 no tick while frozen", tickSeen, 0);
    regRead(8'h4C, v); check("R7 freeze readback", v, 1);
    regWrite(8'h10, 32'h0000_03FF);
    regRead(8'h10, v); check("R8 counter write ignored", v, held);
    regWrite(8'h4C, 32'h0);                    // this edge inactive
    addr = 8'h10;
    repeat (10) @(negedge clk);
    regRead(8'h10, v);
    check("R7 resume keeps phase", v, (base + ((5 + 1 + 10) * 2) / 4) % WRAP);

    // R9 unmapped and upper freeze bits
    regRead(8'h20, v); check("R9 unmapped read", v, 0);
    regWrite(8'h4C, 32'hFFFF_FFFE);
    regRead(8'h4C, v); check("R9 freeze upper bits", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule